// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits in front of a two-port shared memory. Its job is to catch the case where both ports select the same word in the same cycle. Each cycle it compares the enables and addresses of the two ports, named port 0 and port 1.

When it finds a clash, it picks one side to proceed. It then tells the other side, through an active-low busy line, that the memory is occupied. A write strobe from the losing side is gated off before it can reach the array. The arbiter also emits a one-cycle event on every fresh clash, which system logic can use as an interrupt source.

A mode input selects between two roles:
- **Master** (mode high): the instance arbitrates and drives its busy outputs.
- **Slave** (mode low): the instance does no arbitration. Its busy inputs serve only as write inhibits.

With these roles, several instances placed side by side to widen a word can all follow the single decision of one master.

A write is one continuous stretch of cycles on which a port's enable and write strobe are both high. The arbiter samples the inhibit in the first cycle of that stretch and keeps the sampled value until the stretch ends. A write therefore is either passed whole or blocked whole.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: After reset, with both ports idle, both busy outputs are high, the collision event is low and neither gated write strobe is high.
- R2: In master mode, a clash exists when both enables are high and both addresses are equal. During a clash, exactly one busy output is low. With different addresses, both busy outputs stay high.
- R3: The arbitration decision does not depend on the write inputs: a clash between two reads and a clash involving writes produce the same busy outputs.
- R4: If both ports begin selecting the same address in the same cycle, port 0 wins and `p1_busy_n` goes low.
- R5: A port that was already enabled on the clashing address in the previous cycle wins against a newcomer. It keeps the win until its enable drops or its address changes.
- R6: A gated write strobe is high only while that port's enable and write are high. It is held low for a write whose first cycle sees that port's busy low.
- R7: The inhibit value seen in the first cycle of a write holds for every cycle of that write, even if busy changes before the write ends.
- R8: In slave mode, both busy outputs stay high and the collision event stays low. A low busy input blocks writes on its port, and a high busy input lets them through.
- R9: In master mode, the busy inputs have no effect on any output.
- R10: The collision event is high for exactly one cycle when a clash begins. This includes a clash that restarts after an address change or an enable drop. It stays low while the same clash continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs act as write inhibits |
| p0_en | input | 1 | Port 0 select |
| p0_addr | input | AW | Port 0 word address |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_busy_in_n | input | 1 | Port 0 external write inhibit, active low (slave mode) |
| p1_en | input | 1 | Port 1 select |
| p1_addr | input | AW | Port 1 word address |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_busy_in_n | input | 1 | Port 1 external write inhibit, active low (slave mode) |
| p0_busy_n | output | 1 | Port 0 busy, active low (master mode) |
| p1_busy_n | output | 1 | Port 1 busy, active low (master mode) |
| p0_wr_gated | output | 1 | Port 0 write strobe toward the array |
| p1_wr_gated | output | 1 | Port 1 write strobe toward the array |
| collide_evt | output | 1 | One-cycle pulse on each new clash |

## Verification
The bench builds clashes in three ways:
- Both ports arrive at once. A design that ignored the tiebreak would stall port 0 or stall both ports.
- One port is already on the address when the other arrives. A design that granted purely by fixed priority would wrongly stall the incumbent port 1.
- A clash restarts after an address change. This catches a design that remembers the old winner, or one that never re-fires the event.

It also changes busy in the middle of a write, in master mode and in slave mode. A design that re-evaluated the inhibit every cycle would let the tail of a blocked write through, or cut off a granted write. Finally, it toggles the busy inputs in master mode to expose a design that leaks them into the gating.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  // Which side of the pair a decision refers to
  typedef enum logic {
    SIDE_P0 = 1'b0,
    SIDE_P1 = 1'b1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/dpa_port_track.sv
// Per-port tracker: notices whether the port is parked on the same word as
// last cycle and gates its write strobe with an inhibit captured at the first
// cycle of each write.
module dpa_port_track #(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          inhibit,
  output logic          stay,
  output logic          wr_gated
);

  logic [AW-1:0] addr_q, addr_d;
  logic          en_q;
  logic          act_q;
  logic          inh_q, inh_d;
  logic          wr_act;
  logic          wr_start;
  logic          inh_use;

  always_comb begin
    wr_act   = en & wr;
    wr_start = wr_act & ~act_q;
    inh_use  = wr_start ? inhibit : inh_q;
    wr_gated = wr_act & ~inh_use;
    inh_d    = wr_act & inh_use;
    stay     = en & en_q & (addr == addr_q);
    addr_d   = en ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      en_q   <= en;
      act_q  <= wr_act;
      inh_q  <= inh_d;
    end
  end

endmodule

// File: rtl/dpa_arbiter.sv
// Clash detector and grant keeper. Decides which side loses a clash and
// flags the first cycle of each clash.
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          en0,
  input  logic          en1,
  input  logic [AW-1:0] addr0,
  input  logic [AW-1:0] addr1,
  input  logic          stay0,
  input  logic          stay1,
  output logic          clash,
  output side_e         loser,
  output logic          new_clash
);

  logic  clash_q;
  side_e winner_q, winner_d;
  logic  continuing;

  always_comb begin
    clash      = master & en0 & en1 & (addr0 == addr1);
    continuing = clash_q & stay0 & stay1;
    if (continuing) begin
      winner_d = winner_q;
    end else if (stay1 & ~stay0) begin
      winner_d = SIDE_P1;
    end else begin
      winner_d = SIDE_P0;
    end
    loser     = (winner_d == SIDE_P0) ? SIDE_P1 : SIDE_P0;
    new_clash = clash & ~continuing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clash_q  <= 1'b0;
      winner_q <= SIDE_P0;
    end else begin
      clash_q <= clash;
      if (clash) begin
        winner_q <= winner_d;
      end
    end
  end

endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          p0_en,
  input  logic [AW-1:0] p0_addr,
  input  logic          p0_wr,
  input  logic          p0_busy_in_n,
  input  logic          p1_en,
  input  logic [AW-1:0] p1_addr,
  input  logic          p1_wr,
  input  logic          p1_busy_in_n,
  output logic          p0_busy_n,
  output logic          p1_busy_n,
  output logic          p0_wr_gated,
  output logic          p1_wr_gated,
  output logic          collide_evt
);

  localparam int unsigned NS = NUM_SIDES;

  logic [NS-1:0]         en_v, wr_v, busy_in_n_v, busy_out_n_v;
  logic [NS-1:0]         inhibit_v, stay_v, gated_v;
  logic [NS-1:0][AW-1:0] addr_v;
  logic                  clash;
  side_e                 loser;
  logic                  new_clash;

  always_comb begin
    en_v        = {p1_en, p0_en};
    wr_v        = {p1_wr, p0_wr};
    busy_in_n_v = {p1_busy_in_n, p0_busy_in_n};
    addr_v[0]   = p0_addr;
    addr_v[1]   = p1_addr;
  end

  dpa_arbiter #(.AW(AW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (master_mode),
    .en0       (en_v[0]),
    .en1       (en_v[1]),
    .addr0     (addr_v[0]),
    .addr1     (addr_v[1]),
    .stay0     (stay_v[0]),
    .stay1     (stay_v[1]),
    .clash     (clash),
    .loser     (loser),
    .new_clash (new_clash)
  );

  for (genvar s = 0; s < NS; s++) begin : g_side
    always_comb begin
      busy_out_n_v[s] = ~(clash & (loser == side_e'(s)));
      inhibit_v[s]    = master_mode ? ~busy_out_n_v[s] : ~busy_in_n_v[s];
    end

    dpa_port_track #(.AW(AW)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_v[s]),
      .addr     (addr_v[s]),
      .wr       (wr_v[s]),
      .inhibit  (inhibit_v[s]),
      .stay     (stay_v[s]),
      .wr_gated (gated_v[s])
    );
  end

  always_comb begin
    p0_busy_n   = busy_out_n_v[0];
    p1_busy_n   = busy_out_n_v[1];
    p0_wr_gated = gated_v[0];
    p1_wr_gated = gated_v[1];
    collide_evt = new_clash;
  end

endmodule

// File: rtl/dpa_collision_arbiter_chk.sv
module dpa_collision_arbiter_chk #(
  parameter int unsigned AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          p0_en,
  input logic [AW-1:0] p0_addr,
  input logic          p0_wr,
  input logic          p1_en,
  input logic [AW-1:0] p1_addr,
  input logic          p1_wr,
  input logic          p0_busy_n,
  input logic          p1_busy_n,
  input logic          p0_wr_gated,
  input logic          p1_wr_gated,
  input logic          collide_evt
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~p0_busy_n, ~p1_busy_n}) <= 1); // R2

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (p0_busy_n && p1_busy_n && !collide_evt)); // R8

  AST_GATE_P0_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    p0_wr_gated |-> (p0_en && p0_wr)); // R6

  AST_GATE_P1_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    p1_wr_gated |-> (p1_en && p1_wr)); // R6

  AST_P0_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && master_mode && p0_en && p0_wr && !p0_busy_n && !$past(p0_en && p0_wr))
      |-> !p0_wr_gated); // R6

  AST_P1_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && master_mode && p1_en && p1_wr && !p1_busy_n && !$past(p1_en && p1_wr))
      |-> !p1_wr_gated); // R6

  AST_P0_KEEPS_LOSING: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && master_mode && $past(master_mode) && $past(!p0_busy_n) &&
     p0_en && p1_en && $stable(p0_addr) && $stable(p1_addr)) |-> !p0_busy_n); // R5

  AST_P1_KEEPS_LOSING: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && master_mode && $past(master_mode) && $past(!p1_busy_n) &&
     p0_en && p1_en && $stable(p0_addr) && $stable(p1_addr)) |-> !p1_busy_n); // R5

  AST_EVT_HAS_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    collide_evt |-> (!p0_busy_n || !p1_busy_n)); // R10

endmodule

bind dpa_collision_arbiter dpa_collision_arbiter_chk #(.AW(AW)) u_chk (.*);

// File: tb/dpa_collision_arbiter_test.sv
`timescale 1ns/1ps
module dpa_collision_arbiter_test;

  localparam int unsigned AW = 15;

  typedef struct {
    logic  b0, b1, g0, g1, ev;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          master_mode;
  logic          p0_en, p0_wr, p0_busy_in_n;
  logic          p1_en, p1_wr, p1_busy_in_n;
  logic [AW-1:0] p0_addr, p1_addr;
  logic          p0_busy_n, p1_busy_n, p0_wr_gated, p1_wr_gated, collide_evt;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  dpa_collision_arbiter #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .p0_en(p0_en), .p0_addr(p0_addr), .p0_wr(p0_wr), .p0_busy_in_n(p0_busy_in_n),
    .p1_en(p1_en), .p1_addr(p1_addr), .p1_wr(p1_wr), .p1_busy_in_n(p1_busy_in_n),
    .p0_busy_n(p0_busy_n), .p1_busy_n(p1_busy_n),
    .p0_wr_gated(p0_wr_gated), .p1_wr_gated(p1_wr_gated),
    .collide_evt(collide_evt)
  );

  // Driver: applies one cycle of stimulus at the falling edge and queues the
  // outputs the requirements call for in that same cycle.
  task automatic step(input logic md,
                      input logic e0, input logic [AW-1:0] a0, input logic w0,
                      input logic e1, input logic [AW-1:0] a1, input logic w1,
                      input logic bi0, input logic bi1,
                      input logic xb0, input logic xb1, input logic xg0,
                      input logic xg1, input logic xev, input string tag);
    exp_t e;
    @(negedge clk);
    master_mode = md;
    p0_en = e0; p0_addr = a0; p0_wr = w0; p0_busy_in_n = bi0;
    p1_en = e1; p1_addr = a1; p1_wr = w1; p1_busy_in_n = bi1;
    e.b0 = xb0; e.b1 = xb1; e.g0 = xg0; e.g1 = xg1; e.ev = xev; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each queued item against the ports mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if ({p0_busy_n, p1_busy_n, p0_wr_gated, p1_wr_gated, collide_evt} !==
            {e.b0, e.b1, e.g0, e.g1, e.ev}) begin
          fails++;
          $display("FAIL %s: actual busy_n=%b%b gated=%b%b evt=%b expected busy_n=%b%b gated=%b%b evt=%b",
                   e.tag, p0_busy_n, p1_busy_n, p0_wr_gated, p1_wr_gated, collide_evt,
                   e.b0, e.b1, e.g0, e.g1, e.ev);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still going expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    master_mode = 1'b1;
    p0_en = 1'b0; p0_addr = '0; p0_wr = 1'b0; p0_busy_in_n = 1'b1;
    p1_en = 1'b0; p1_addr = '0; p1_wr = 1'b0; p1_busy_in_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    //    md e0 a0       w0 e1 a1       w1 bi0 bi1  b0 b1 g0 g1 ev
    step(1, 0, 15'h0000, 0, 0, 15'h0000, 0, 1, 1,   1, 1, 0, 0, 0, "R1 idle after reset");
    step(1, 1, 15'h0005, 0, 1, 15'h0009, 0, 1, 1,   1, 1, 0, 0, 0, "R2 different addresses");
    step(1, 1, 15'h0005, 0, 1, 15'h0005, 0, 1, 1,   1, 0, 0, 0, 1, "R5 port0 incumbent wins");
    step(1, 1, 15'h0005, 0, 1, 15'h0005, 0, 1, 1,   1, 0, 0, 0, 0, "R10 no repeat while clash lasts");
    step(1, 1, 15'h0005, 0, 1, 15'h0005, 1, 1, 1,   1, 0, 0, 0, 0, "R6 loser write blocked");
    step(1, 1, 15'h0005, 1, 1, 15'h0005, 1, 1, 1,   1, 0, 1, 0, 0, "R6 winner write passes");
    step(1, 0, 15'h0000, 0, 0, 15'h0000, 0, 1, 1,   1, 1, 0, 0, 0, "R2 release");
    step(1, 1, 15'h7FFF, 0, 1, 15'h7FFF, 0, 1, 1,   1, 0, 0, 0, 1, "R4 simultaneous arrival");
    step(1, 0, 15'h0000, 0, 0, 15'h0000, 0, 1, 1,   1, 1, 0, 0, 0, "R2 release");
    step(1, 0, 15'h0000, 0, 1, 15'h0020, 0, 1, 1,   1, 1, 0, 0, 0, "R2 single port");
    step(1, 1, 15'h0020, 1, 1, 15'h0020, 0, 1, 1,   0, 1, 0, 0, 1, "R5 port1 incumbent wins");
    step(1, 1, 15'h0020, 1, 1, 15'h0020, 0, 1, 1,   0, 1, 0, 0, 0, "R5 grant kept");
    step(1, 1, 15'h0020, 1, 1, 15'h0021, 0, 1, 1,   1, 1, 0, 0, 0, "R7 blocked write stays blocked");
    step(1, 1, 15'h0020, 1, 1, 15'h0020, 0, 1, 1,   1, 0, 0, 0, 1, "R10 clash restart");
    step(1, 1, 15'h0020, 0, 1, 15'h0020, 0, 1, 1,   1, 0, 0, 0, 0, "R3 read clash same decision");
    step(1, 1, 15'h0020, 1, 1, 15'h0020, 0, 1, 1,   1, 0, 1, 0, 0, "R3 write does not change grant");
    step(1, 1, 15'h0020, 1, 1, 15'h0020, 0, 0, 0,   1, 0, 1, 0, 0, "R9 busy inputs ignored");
    step(1, 0, 15'h0000, 0, 0, 15'h0000, 0, 1, 1,   1, 1, 0, 0, 0, "R2 release");
    step(0, 1, 15'h0003, 1, 1, 15'h0003, 1, 1, 0,   1, 1, 1, 0, 0, "R8 slave inhibit inputs");
    step(0, 1, 15'h0003, 1, 1, 15'h0003, 1, 0, 1,   1, 1, 1, 0, 0, "R7 slave inhibit held");
    step(0, 1, 15'h0003, 0, 1, 15'h0003, 0, 0, 1,   1, 1, 0, 0, 0, "R8 writes end");
    step(0, 1, 15'h0003, 1, 1, 15'h0003, 1, 0, 1,   1, 1, 0, 1, 0, "R8 new writes follow inputs");
    step(0, 0, 15'h0000, 0, 0, 15'h0000, 0, 1, 1,   1, 1, 0, 0, 0, "R8 idle slave");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule